// File: doc/BRIEF.md
# Floppy Flux Interval Capture Engine

This block times the gaps between flux-transition pulses arriving on a floppy drive's read-data line and pushes each gap, as an unsigned 8-bit tick count, into a downstream byte FIFO. The host side then sees raw pulse timing rather than decoded bits. This lets software judge marginal pulses, apply its own acceptance windows for the short, medium and long double-density cells (nominally 4, 6 and 8 us), and gather statistics on them.

A one-cycle `start` pulse arms the engine. Idle time before the first flux transition is thrown away: that first transition only opens a fixed capture window, which by default lasts 225 ms, slightly more than one revolution. Every later transition inside the window writes the interval since the previous accepted transition, one cycle after it is measured, so the transfer to the host overlaps the capture. The read-data line is active low and asynchronous. It is synchronised and its falling edge is detected. After each accepted edge a lockout of about 1 us stops one physical pulse from being counted twice. Counts saturate at 255. A write that meets a full FIFO is dropped and latches a sticky overflow flag.

The controller has four states. IDLE waits for `start` and moves to ARM. ARM waits for the first accepted edge and moves to CAPTURE. CAPTURE writes intervals and moves to FINISH when the window expires. FINISH raises `done` for one cycle and always returns to IDLE.

Top module: `flux_capture`

## Requirements
- R1: A falling edge of `rd_n` (high to low, since the line is active low) that is accepted in the CAPTURE state produces exactly one single-cycle `fifo_wr` pulse. `fifo_data` carries the number of ticks (one tick = CLK_DIV clock cycles) elapsed since the previous accepted edge. With edges N cycles apart and N a multiple of CLK_DIV, the value is N/CLK_DIV.
- R2: An interval longer than 255 ticks is written as 255 and never wraps.
- R3: After `start`, the first accepted falling edge writes nothing and only opens the window. The idle wait before it has no effect on any recorded value.
- R4: A falling edge arriving fewer than LOCK_TICKS ticks after an accepted edge is ignored. The interval keeps running from the accepted edge. An edge exactly LOCK_TICKS ticks later is accepted.
- R5: In IDLE, transitions on `rd_n` produce no `fifo_wr` and leave `busy` low.
- R6: The window closes WINDOW_TICKS ticks after the first accepted edge (within a few cycles). No edge after that produces a write.
- R7: `busy` is high from the cycle after `start` until the window closes. `done` is then high for exactly one cycle, with `busy` low. After reset, `busy`, `done`, `fifo_wr` and `overflow` are all low.
- R8: If `fifo_full` is high in the cycle a write is due, no `fifo_wr` is issued and `overflow` goes high. The dropped edge still counts as accepted, so the next interval is measured from it.
- R9: `overflow` stays high through the rest of the capture and after `done`. It is cleared only by a `start` taken in IDLE.
- R10: A `start` pulse while the engine is busy is ignored. Capture, recorded values and `overflow` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to arm a capture |
| rd_n | input | 1 | Asynchronous active-low read-data pulse line from the drive |
| fifo_full | input | 1 | Downstream FIFO cannot accept a byte |
| fifo_wr | output | 1 | Write strobe to the FIFO, one cycle per interval |
| fifo_data | output | DATA_W | Interval in ticks, saturated |
| busy | output | 1 | Engine is in ARM or CAPTURE |
| done | output | 1 | One-cycle pulse when the window has closed |
| overflow | output | 1 | Sticky flag: at least one interval was dropped on a full FIFO |

## Verification
The main function is driven with a train of even-cycle gaps of graded length, which shows linear tick scaling. Gaps just above and far above the 8-bit range separate saturation from wrap-around. Glitch gaps well below, just below and exactly at the lockout length show whether the lockout and the continued interval count are right at its boundary. A long wait before the first edge, a steady train that runs past the window end, and a FIFO-full period inside a train show, respectively, that pre-edge idle time is discarded, that the window length is measured from the first edge, and that a dropped sample neither shifts later intervals nor escapes the overflow flag.

// File: rtl/flux_pkg.sv
package flux_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FINISH  = 2'd3
    } cap_state_t;

endpackage

// File: rtl/flux_edge_sync.sv
module flux_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    assign fall = last_q & ~chain_q[STAGES-1];

    // A detected fall is a single-cycle event (supports R4)
    assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/flux_tick_gen.sv
module flux_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                          cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))      cnt_q <= '0;
                else                                 cnt_q <= cnt_q + CW'(1);
            end
            assign tick = (cnt_q == CW'(DIV - 1));

            // Ticks never come back to back when dividing (R1 resolution)
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/flux_interval_meter.sv
module flux_interval_meter #(
    parameter int WIDTH      = 8,
    parameter int LOCK_TICKS = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             tick,
    input  logic             fall,
    output logic             accept,
    output logic [WIDTH-1:0] interval
);
    localparam int LW = $clog2(LOCK_TICKS + 1);
    localparam logic [WIDTH-1:0] TOP = '1;

    logic [WIDTH-1:0] cnt_q;
    logic [LW-1:0]    lock_q;

    assign accept   = enable && fall && (lock_q == '0);
    assign interval = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            lock_q <= '0;
        end else if (accept) begin
            // the accept cycle itself is the first cycle of the new interval
            cnt_q  <= tick ? WIDTH'(1) : '0;
            lock_q <= LW'(LOCK_TICKS) - LW'(tick);
        end else if (tick) begin
            cnt_q  <= (cnt_q == TOP) ? TOP : cnt_q + WIDTH'(1);
            if (lock_q != '0) lock_q <= lock_q - LW'(1);
        end
    end

    assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !accept && cnt_q == TOP) |=> (cnt_q == TOP));
endmodule

// File: rtl/flux_window_timer.sv
module flux_window_timer #(
    parameter int WINDOW_TICKS = 5625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(WINDOW_TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= tick ? CW'(1) : '0;
        else if (run && tick) cnt_q <= cnt_q + CW'(1);
    end

    assign expire = run && tick && (cnt_q == CW'(WINDOW_TICKS - 1));

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CW'(WINDOW_TICKS)));
endmodule

// File: rtl/flux_capture.sv
module flux_capture
    import flux_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int LOCK_TICKS   = 25,
    parameter int WINDOW_TICKS = 5625000,
    parameter int DATA_W       = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_n,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              busy,
    output logic              done,
    output logic              overflow
);
    cap_state_t        state_q, state_d;
    logic              tick, fall, accept, expire;
    logic [DATA_W-1:0] interval;
    logic              meter_clear, meter_en, win_load, win_run, wr_due;

    flux_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rd_n), .fall(fall));

    flux_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    flux_interval_meter #(.WIDTH(DATA_W), .LOCK_TICKS(LOCK_TICKS)) u_meter (
        .clk(clk), .rst_n(rst_n), .clear(meter_clear), .enable(meter_en),
        .tick(tick), .fall(fall), .accept(accept), .interval(interval));

    flux_window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
        .clk(clk), .rst_n(rst_n), .load(win_load), .run(win_run),
        .tick(tick), .expire(expire));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)  state_d = ST_ARM;
            ST_ARM:     if (accept) state_d = ST_CAPTURE;
            ST_CAPTURE: if (expire) state_d = ST_FINISH;
            ST_FINISH:              state_d = ST_IDLE;
        endcase
    end

    // state-decoded controls
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        meter_clear = 1'b0;
        meter_en    = 1'b0;
        win_load    = 1'b0;
        win_run     = 1'b0;
        wr_due      = 1'b0;
        unique case (state_q)
            ST_IDLE: meter_clear = 1'b1;
            ST_ARM: begin
                busy     = 1'b1;
                meter_en = 1'b1;
                win_load = accept;
            end
            ST_CAPTURE: begin
                busy     = 1'b1;
                meter_en = 1'b1;
                win_run  = 1'b1;
                wr_due   = accept;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

    // FIFO write port and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            overflow  <= 1'b0;
        end else begin
            fifo_wr <= wr_due && !fifo_full;
            if (wr_due && !fifo_full) fifo_data <= interval;
            if (state_q == ST_IDLE && start)  overflow <= 1'b0;
            else if (wr_due && fifo_full)     overflow <= 1'b1;
        end
    end

    assert_no_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !$past(fifo_full));

    assert_overflow_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_due && fifo_full) |=> overflow);

    assert_overflow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(state_q == ST_IDLE && start)) |=> overflow);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !fifo_wr);

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_first_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> !fifo_wr);
endmodule

// File: tb/sim_flux_capture.sv
module sim_flux_capture;
    localparam int CLK_DIV      = 2;
    localparam int LOCK_TICKS   = 25;
    localparam int WINDOW_TICKS = 2500;
    localparam int PW           = 4;
    localparam int LOCK_CYC     = LOCK_TICKS * CLK_DIV;
    localparam int WIN_CYC      = WINDOW_TICKS * CLK_DIV;
    localparam int NROW         = 12;
    // gaps in clock cycles between successive falling edges of rd_n
    localparam int GAPS [NROW] = '{200, 300, 400, 100, 10, 190, 48, 152, 50, 510, 508, 600};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_n = 1'b1, fifo_full = 1'b0;
    logic fifo_wr, busy, done, overflow;
    logic [7:0] fifo_data;

    flux_capture #(.CLK_DIV(CLK_DIV), .LOCK_TICKS(LOCK_TICKS),
                   .WINDOW_TICKS(WINDOW_TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_n(rd_n), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .busy(busy), .done(done),
        .overflow(overflow));

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    int cyc = 0, nlog = 0, done_seen = 0, t_done = 0;
    logic [7:0] log_q [64];

    always @(negedge clk) begin
        cyc++;
        if (fifo_wr) begin
            if (nlog < 64) log_q[nlog] = fifo_data;
            nlog++;
        end
        if (done) begin
            done_seen++;
            t_done = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic first_fall();
        @(negedge clk) rd_n = 1'b0;
    endtask

    task automatic release_line();
        repeat (PW) @(negedge clk);
        rd_n = 1'b1;
    endtask

    // next falling edge n cycles after the previous one; act: 0 none,
    // 1 start pulse, 2 raise fifo_full, 3 drop fifo_full (mid-gap)
    task automatic gap_fall(input int n, input int act);
        repeat (PW) @(negedge clk);
        rd_n = 1'b1;
        if (act == 0) begin
            repeat (n - PW) @(negedge clk);
        end else begin
            repeat (10) @(negedge clk);
            if (act == 1) begin
                start = 1'b1;
                @(negedge clk) start = 1'b0;
                repeat (n - PW - 11) @(negedge clk);
            end else begin
                fifo_full = (act == 2);
                repeat (n - PW - 10) @(negedge clk);
            end
        end
        rd_n = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done, req, done, 1);
        @(negedge clk);
        check(!done && !busy, req, {30'd0, done, busy}, 0);
    endtask

    initial begin
        repeat (200000 - 1000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base, exp_n, acc, val, d0, t0;
        bit prev_rej;
        int exp_v [NROW];
        string exp_tag [NROW];

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fifo_wr, "R7 reset fifo_wr", fifo_wr, 0);
        check(!busy, "R7 reset busy", busy, 0);
        check(!done, "R7 reset done", done, 0);
        check(!overflow, "R9 reset overflow", overflow, 0);

        // R5: edges while idle do nothing
        base = nlog;
        first_fall();
        for (int i = 0; i < 3; i++) gap_fall(100, 0);
        release_line();
        repeat (20) @(negedge clk);
        check(nlog == base, "R5 idle writes", nlog - base, 0);
        check(!busy, "R5 idle busy", busy, 0);

        // expected values from the gap table, computed from the requirements
        acc = 0; exp_n = 0; prev_rej = 1'b0;
        for (int i = 0; i < NROW; i++) begin
            acc += GAPS[i];
            if (acc >= LOCK_CYC) begin
                val = acc / CLK_DIV;
                if (val > 255) val = 255;
                exp_v[exp_n] = val;
                exp_tag[exp_n] = (val == 255) ? "R2 saturation" :
                                 ((prev_rej || acc == LOCK_CYC) ? "R4 lockout" : "R1 interval");
                exp_n++;
                acc = 0;
                prev_rej = 1'b0;
            end else begin
                prev_rej = 1'b1;
            end
        end

        // table run: long idle before first edge, start poked mid-train
        do_start();
        check(busy, "R7 busy after start", busy, 1);
        repeat (1000) @(negedge clk);
        check(nlog == base, "R3 nothing before first edge", nlog - base, 0);
        first_fall();
        for (int i = 0; i < NROW; i++) gap_fall(GAPS[i], (i == 3) ? 1 : 0);
        release_line();
        wait_done("R7 done after table");
        check(nlog - base == exp_n, "R3 write count (first edge silent)", nlog - base, exp_n);
        for (int k = 0; k < exp_n; k++)
            check(int'(log_q[base + k]) == exp_v[k], exp_tag[k], log_q[base + k], exp_v[k]);

        // R6: steady train running past the end of the window
        do_start();
        repeat (50) @(negedge clk);
        base = nlog;
        d0 = done_seen;
        @(negedge clk) rd_n = 1'b0;
        t0 = cyc;
        for (int i = 0; i < 19; i++) gap_fall(300, 0);
        release_line();
        repeat (20) @(negedge clk);
        check(nlog - base == 16, "R6 writes inside window", nlog - base, 16);
        check(done_seen - d0 == 1, "R7 single done", done_seen - d0, 1);
        check((t_done - t0) >= WIN_CYC - 5 && (t_done - t0) <= WIN_CYC + 10,
              "R6 window length", t_done - t0, WIN_CYC);
        check(!busy, "R6 idle after window", busy, 0);
        for (int k = 0; k < 16; k++)
            check(int'(log_q[base + k]) == 150, "R1 steady interval", log_q[base + k], 150);

        // R8/R9/R10: full FIFO drops one sample; start while busy ignored
        do_start();
        check(!overflow, "R9 overflow clear at start", overflow, 0);
        base = nlog;
        first_fall();
        gap_fall(200, 0);
        gap_fall(200, 2);
        gap_fall(200, 3);
        gap_fall(200, 1);
        release_line();
        repeat (10) @(negedge clk);
        check(nlog - base == 3, "R8 dropped sample", nlog - base, 3);
        check(overflow, "R8 overflow set", overflow, 1);
        check(busy, "R10 still busy after start", busy, 1);
        for (int k = 0; k < 3; k++)
            check(int'(log_q[base + k]) == 100, "R8 interval from dropped edge", log_q[base + k], 100);
        wait_done("R7 done after overflow run");
        check(overflow, "R9 overflow sticky after done", overflow, 1);
        do_start();
        check(!overflow, "R9 overflow cleared by start", overflow, 0);
        first_fall();
        release_line();
        wait_done("R7 done final");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule